// File: doc/BRIEF.md
# Configurable Lookup Logic Cell

This block is one tile of a programmable logic fabric. It keeps a small writable truth table of eight rows, each two bits wide. Three logic inputs form the row index, and the selected row gives two result bits. Storing the truth table of a function makes the cell compute it, so the cell can realise any function with three inputs and two outputs. The table is loaded at run time through a configuration port. That port has a row address, two data bits and a read/write control. A value of 0 on the control requests a write and a value of 1 requests a read.

Each result bit has its own D flip-flop. A per-output mode bit, stored alongside the table, picks what that output shows. In `OUT_COMB` mode the output is the raw lookup bit, with no clock involved. In `OUT_REG` mode the output is the flip-flop. Registered outputs fed back into the logic inputs of one or more cells build sequential circuits such as counters.

The cell has no state machine. Its only sequential elements are the table rows, the two mode bits and the two output flip-flops. The configuration control has two named operations, `CFG_WRITE` (0) and `CFG_READ` (1), and each output has two named modes, `OUT_COMB` (0) and `OUT_REG` (1). An output changes mode only when a configuration write loads a new mode bit.

Top module: `lcell_lut_block`

## Requirements
- R1: The table rows and both mode bits start as zero, so once reset has been applied both outputs read 0 for every input combination until the cell is configured.
- R2: On a rising clock edge with `cfg_rw` = 0, row `cfg_addr` takes the value `cfg_wdata`. Bit 1 of the row drives `y[1]` and bit 0 drives `y[0]`. The row index is `{lin[2], lin[1], lin[0]}`.
- R3: On a rising clock edge with `cfg_rw` = 1, no row changes, whatever values are on `cfg_addr` and `cfg_wdata`.
- R4: When mode bit i is 0 (`OUT_COMB`), `y[i]` follows bit i of the row selected by `lin` combinationally, within the same cycle.
- R5: When mode bit i is 1 (`OUT_REG`), `y[i]` equals bit i of the row that `lin` selected at the previous rising clock edge.
- R6: Each configuration write also loads `cfg_mode` into the two mode bits. The two mode bits act independently: bit i controls only `y[i]`.
- R7: A synchronous active-high `rst` clears both output flip-flops to 0. It leaves the table rows and the mode bits unchanged.
- R8: A configuration write does not disturb the flip-flops. On the writing edge they capture the row value as it was before that write.
- R9: With full-adder contents loaded and inputs (X, Y, Cin) on `lin[2:0]`, `y[1]` is the carry-out and `y[0]` is the sum for all eight combinations.
- R10: With ones-count contents loaded, `y` equals the number of 1 bits on `lin`. For example, `lin` = 101 gives `y` = 10.
- R11: Two cells in `OUT_REG` mode, with their registered outputs fed back as the three inputs, form a free-running 3-bit counter that starts at 0 after reset and advances by one on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output flip-flops |
| cfg_addr | input | 3 | Table row to be written |
| cfg_wdata | input | 2 | New row contents; bit 1 feeds y[1], bit 0 feeds y[0] |
| cfg_rw | input | 1 | 0 = write (CFG_WRITE), 1 = read/idle (CFG_READ) |
| cfg_mode | input | 2 | Per-output mode loaded on a write; 1 = registered, 0 = combinational |
| lin | input | 3 | Logic inputs; form the table row index |
| y | output | 2 | Cell outputs |

## Verification
A configuration write becomes visible one edge after it is applied. Combinational outputs are therefore checked one nanosecond after the inputs change at a falling edge, with no clock edge in between. Registered outputs are due on the first rising edge after `lin` is applied, so the bench waits exactly that one edge and samples one nanosecond later. The write-collision case expects the old row on that first edge and the new row on the second. The counter check samples at each falling edge and expects one increment per rising edge since reset was released.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
    localparam int LC_IN_W  = 3;
    localparam int LC_OUT_W = 2;

    typedef enum logic {
        CFG_WRITE = 1'b0,
        CFG_READ  = 1'b1
    } cfg_op_e;

    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;
endpackage

// File: rtl/lcell_table.sv
module lcell_table #(
    parameter int IN_W  = 3,
    parameter int OUT_W = 2
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IN_W-1:0]  wr_addr,
    input  logic [OUT_W-1:0] wr_data,
    input  logic [IN_W-1:0]  rd_addr,
    output logic [OUT_W-1:0] rd_data
);
    localparam int ROWS = 1 << IN_W;

    logic [OUT_W-1:0] rows [ROWS] = '{default: '0};

    always_ff @(posedge clk) begin
        if (wr_en) begin
            rows[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_data = rows[rd_addr];
    end
endmodule

// File: rtl/lcell_mode_reg.sv
module lcell_mode_reg #(
    parameter int OUT_W = 2
) (
    input  logic             clk,
    input  logic             load,
    input  logic [OUT_W-1:0] mode_in,
    output logic [OUT_W-1:0] mode_q
);
    logic [OUT_W-1:0] mode_r = '0;

    always_ff @(posedge clk) begin
        if (load) begin
            mode_r <= mode_in;
        end
    end

    assign mode_q = mode_r;
endmodule

// File: rtl/lcell_out_bit.sv
module lcell_out_bit
    import lcell_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      d,
    input  out_mode_e mode,
    output logic      q,
    output logic      y
);
    logic q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= 1'b0;
        end else begin
            q_r <= d;
        end
    end

    always_comb begin
        unique case (mode)
            OUT_COMB: y = d;
            OUT_REG:  y = q_r;
            default:  y = d;
        endcase
    end

    assign q = q_r;
endmodule

// File: rtl/lcell_lut_block.sv
module lcell_lut_block
    import lcell_pkg::*;
#(
    parameter int IN_W  = LC_IN_W,
    parameter int OUT_W = LC_OUT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  cfg_addr,
    input  logic [OUT_W-1:0] cfg_wdata,
    input  logic             cfg_rw,
    input  logic [OUT_W-1:0] cfg_mode,
    input  logic [IN_W-1:0]  lin,
    output logic [OUT_W-1:0] y
);
    cfg_op_e          cfg_op;
    logic             cfg_wr;
    logic [OUT_W-1:0] lut_val;
    logic [OUT_W-1:0] mode_q;
    logic [OUT_W-1:0] reg_q;

    always_comb begin
        cfg_op = cfg_op_e'(cfg_rw);
        unique case (cfg_op)
            CFG_WRITE: cfg_wr = 1'b1;
            CFG_READ:  cfg_wr = 1'b0;
            default:   cfg_wr = 1'b0;
        endcase
    end

    lcell_table #(.IN_W(IN_W), .OUT_W(OUT_W)) u_table (
        .clk     (clk),
        .wr_en   (cfg_wr),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .rd_addr (lin),
        .rd_data (lut_val)
    );

    lcell_mode_reg #(.OUT_W(OUT_W)) u_mode (
        .clk     (clk),
        .load    (cfg_wr),
        .mode_in (cfg_mode),
        .mode_q  (mode_q)
    );

    for (genvar i = 0; i < OUT_W; i++) begin : g_out
        lcell_out_bit u_bit (
            .clk  (clk),
            .rst  (rst),
            .d    (lut_val[i]),
            .mode (out_mode_e'(mode_q[i])),
            .q    (reg_q[i]),
            .y    (y[i])
        );
    end
endmodule

// File: rtl/lcell_lut_block_chk.sv
module lcell_lut_block_chk #(
    parameter int IN_W  = 3,
    parameter int OUT_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [IN_W-1:0]  cfg_addr,
    input logic [OUT_W-1:0] cfg_wdata,
    input logic             cfg_rw,
    input logic [OUT_W-1:0] cfg_mode,
    input logic [IN_W-1:0]  lin,
    input logic [OUT_W-1:0] lut_val,
    input logic [OUT_W-1:0] mode_q,
    input logic [OUT_W-1:0] reg_q
);
    // R2: a written row is read back on the next cycle when it is selected
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        !cfg_rw |=> (lin != $past(cfg_addr)) || (lut_val == $past(cfg_wdata)));

    // R3: without a write the selected row stays as it was
    assert_read_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_rw |=> (!$stable(lin)) || $stable(lut_val));

    // R5, R8: flip-flops capture the pre-edge lookup value
    assert_flop_capture_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> reg_q == $past(lut_val));

    // R6: mode bits load on every configuration write
    assert_mode_load_R6: assert property (@(posedge clk) disable iff (rst)
        !cfg_rw |=> mode_q == $past(cfg_mode));

    // R7: reset clears the flip-flops
    assert_reset_clear_R7: assert property (@(posedge clk)
        rst |=> reg_q == '0);
endmodule

bind lcell_lut_block lcell_lut_block_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rw    (cfg_rw),
    .cfg_mode  (cfg_mode),
    .lin       (lin),
    .lut_val   (lut_val),
    .mode_q    (mode_q),
    .reg_q     (reg_q)
);

// File: tb/lcell_lut_block_test.sv
`timescale 1ns/1ps
module lcell_lut_block_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_addr = '0;
    logic [1:0] cfg_wdata = '0;
    logic       cfg_rw = 1'b1;
    logic [1:0] cfg_mode = '0;
    logic [2:0] lin = '0;
    logic [1:0] y;

    logic       rw_a = 1'b1;
    logic       rw_b = 1'b1;
    logic [1:0] ya, yb;
    logic [2:0] cnt;

    int applied = 0;
    int failed  = 0;
    logic [1:0] model [8];

    always #2.5 clk = ~clk;

    lcell_lut_block uut (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rw(cfg_rw), .cfg_mode(cfg_mode), .lin(lin), .y(y)
    );

    assign cnt = {yb[0], ya[1], ya[0]};

    lcell_lut_block cnt_lo (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rw(rw_a), .cfg_mode(cfg_mode), .lin(cnt), .y(ya)
    );
    lcell_lut_block cnt_hi (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rw(rw_b), .cfg_mode(cfg_mode), .lin(cnt), .y(yb)
    );

    task automatic check(input logic [2:0] got, input logic [2:0] exp, input string req);
        applied++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
        $finish;
    endtask

    task automatic write_row(input logic [2:0] a, input logic [1:0] d, input logic [1:0] m);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_mode = m; cfg_rw = 1'b0;
        @(posedge clk);
        @(negedge clk);
        cfg_rw = 1'b1;
        model[a] = d;
    endtask

    task automatic comb_sweep(input string req);
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            lin = 3'(v);
            #1 check({1'b0, y}, {1'b0, model[v]}, req);
        end
    endtask

    task automatic reg_sweep(input string req);
        for (int v = 7; v >= 0; v--) begin
            @(negedge clk);
            lin = 3'(v);
            @(posedge clk);
            #1 check({1'b0, y}, {1'b0, model[v]}, req);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failed++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [1:0] d;
        repeat (3) @(posedge clk);
        // R1: empty cell reads zero
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            lin = 3'(v);
            #1 check({1'b0, y}, 3'b000, "R1");
        end
        @(negedge clk);
        rst = 1'b0;
        for (int v = 0; v < 8; v++) model[v] = 2'b00;

        // R2, R4, R5: random tables in both modes
        for (int t = 0; t < 6; t++) begin
            for (int r = 0; r < 8; r++) write_row(3'(r), 2'($urandom), 2'b00);
            comb_sweep("R2/R4 comb");
            write_row(3'd0, model[0], 2'b11);
            reg_sweep("R5 reg");
        end

        // R3: reads change nothing
        for (int r = 0; r < 8; r++) write_row(3'(r), 2'(r), 2'b00);
        @(negedge clk);
        cfg_rw = 1'b1; cfg_addr = 3'd5; cfg_wdata = 2'b10;
        repeat (3) @(posedge clk);
        comb_sweep("R3");

        // R6: mixed modes, y[0] combinational and y[1] registered
        write_row(3'd1, 2'b11, 2'b10);
        write_row(3'd2, 2'b00, 2'b10);
        @(negedge clk);
        lin = 3'd1;
        @(posedge clk);
        @(negedge clk);
        lin = 3'd2;
        #1 check({1'b0, y}, 3'b010, "R6 mixed before edge");
        @(posedge clk);
        #1 check({1'b0, y}, 3'b000, "R6 mixed after edge");

        // R8: write to the selected row in registered mode
        write_row(3'd6, 2'b01, 2'b11);
        @(negedge clk);
        lin = 3'd6;
        @(posedge clk);
        @(negedge clk);
        cfg_addr = 3'd6; cfg_wdata = 2'b10; cfg_mode = 2'b11; cfg_rw = 1'b0;
        @(posedge clk);
        #1 check({1'b0, y}, 3'b001, "R8 old value on writing edge");
        @(negedge clk);
        cfg_rw = 1'b1;
        model[6] = 2'b10;
        @(posedge clk);
        #1 check({1'b0, y}, 3'b010, "R8 new value next edge");

        // R7: reset clears flops, keeps contents and modes
        write_row(3'd3, 2'b11, 2'b11);
        @(negedge clk);
        lin = 3'd3;
        @(posedge clk);
        #1 check({1'b0, y}, 3'b011, "R7 loaded");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 check({1'b0, y}, 3'b000, "R7 cleared");
        @(negedge clk);
        rst = 1'b0;
        #1 check({1'b0, y}, 3'b000, "R7 mode kept");
        @(posedge clk);
        #1 check({1'b0, y}, 3'b011, "R7 contents kept");

        // R9: full adder, lin = {X, Y, Cin}
        for (int r = 0; r < 8; r++) begin
            d[1] = (r[2] & r[1]) | (r[2] & r[0]) | (r[1] & r[0]);
            d[0] = r[2] ^ r[1] ^ r[0];
            write_row(3'(r), d, 2'b00);
        end
        comb_sweep("R9 adder");

        // R10: ones count
        for (int r = 0; r < 8; r++) write_row(3'(r), 2'($countones(3'(r))), 2'b11);
        reg_sweep("R10 ones");
        @(negedge clk);
        write_row(3'd0, 2'b00, 2'b00);
        @(negedge clk);
        lin = 3'b101;
        #1 check({1'b0, y}, 3'b010, "R10 101 gives 10");

        // R11: two-cell counter
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            cfg_addr = 3'(r); cfg_mode = 2'b11;
            cfg_wdata = 2'(r + 1); rw_a = 1'b0; rw_b = 1'b1;
            @(negedge clk);
            cfg_wdata = {1'b0, 1'(((r + 1) >> 2) & 1)}; rw_a = 1'b1; rw_b = 1'b0;
            @(negedge clk);
            rw_b = 1'b1;
        end
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(cnt, 3'd0, "R11 start");
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            check(cnt, 3'(k), "R11 count");
        end

        finish_run();
    end
endmodule